// File: doc/BRIEF.md
# Endian-Aware Sequential Host Data Port

This block sits between a 16-bit host data bus and a 32-bit internal word stream. The host reaches it through a single data port that decodes no address bits. Each read or write strobe simply takes the next half of the current 32-bit word. Writing a remote transfer command restarts the sequence. The first data access after the command is the even access, the next is the odd access, and the two keep alternating. One even/odd pair moves one internal word.

A mode register selects the byte order. A zero value, which is the reset default, gives little-endian order. In that order the even access carries bytes 1:0 and the odd access carries bytes 3:2. Any nonzero value gives big-endian order, which swaps the halves: the even access carries bytes 3:2 and the odd access carries bytes 1:0. A status output reports which order is active.

On the read path, an even access fetches a new word from the internal side. The odd access returns the other half of that stored word and fetches nothing. On the write path, an even access holds its half. The odd access completes the word and pushes it inward.

Top module: `seq_data_port`

## Requirements
- R1: After reset the phase is even, `big_endian_o` is 0, `push_o` is 0, `push_data_o` is 0 and `host_rdata_o` is 0.
- R2: A cycle with `cmd_wr_i` high makes the next data access even. A `dp_rd_i` or `dp_wr_i` in that same cycle is ignored: it causes no fetch, no push, no read data update and no phase change.
- R3: Every accepted access toggles one shared phase, whether it is a read or a write. When `dp_rd_i` and `dp_wr_i` are high together, the access counts as a read only and the write data is dropped.
- R4: In little-endian mode, a read returns its data on `host_rdata_o` from the cycle after the strobe. An even read returns word[15:0] (byte1 on [15:8], byte0 on [7:0]). An odd read returns word[31:16] (byte3 on [15:8], byte2 on [7:0]).
- R5: In big-endian mode, an even read returns word[31:16] and an odd read returns word[15:0], with the same one-cycle latency.
- R6: `fetch_o` is high, combinationally, only in the cycle of an accepted even read, and `fetch_data_i` is sampled in that cycle. An odd read uses the stored word and ignores `fetch_data_i`.
- R7: In little-endian mode, even write data becomes word[15:0] and odd write data becomes word[31:16]. `push_o` pulses for one cycle, in the cycle after the odd write, with the word on `push_data_o`.
- R8: In big-endian mode, even write data becomes word[31:16] and odd write data becomes word[15:0].
- R9: An even write alone never raises `push_o`.
- R10: `big_endian_o` is 1 exactly when the mode register is nonzero. A mode write takes effect in the following cycle. For example, 0x0100 selects big-endian order and 0x0000 selects little-endian order.
- R11: `host_rdata_o` changes only in the cycle after an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Host wrote the remote transfer command; restarts at even phase |
| mode_wr_i | input | 1 | Write strobe for the mode register |
| mode_data_i | input | MODE_W (16) | Mode register write value |
| dp_rd_i | input | 1 | Host data port read strobe |
| dp_wr_i | input | 1 | Host data port write strobe |
| host_wdata_i | input | HALF_W (16) | Host write data |
| host_rdata_o | output | HALF_W (16) | Host read data, valid the cycle after a read |
| big_endian_o | output | 1 | Status: 1 when the mode register is nonzero |
| fetch_o | output | 1 | Request for the next internal word (even read) |
| fetch_data_i | input | 2*HALF_W (32) | Internal word, sampled while fetch_o is high |
| push_o | output | 1 | One-cycle strobe for an assembled write word |
| push_data_o | output | 2*HALF_W (32) | Assembled write word |

## Verification
The bench uses word values with four distinct bytes, so any swap of the upper and lower halves in either mode shows up as wrong read data or a wrong pushed word. An odd read is issued while `fetch_data_i` carries junk; a design that fetched again on the odd access would return that junk. Command writes are placed in mid-pair and together with a read strobe; a design that did not restart the phase, or that accepted the colliding access, would shift every later lane by one half. Mixed read/write pairs and simultaneous strobes check that one shared phase is kept, and a lone even write checks that no early push appears.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  typedef enum logic {PH_EVEN = 1'b0, PH_ODD = 1'b1} phase_e;
endpackage

// File: rtl/sdp_phase.sv
module sdp_phase
  import sdp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_wr_i,
  input  logic access_i,
  output logic odd_o
);
  phase_e ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ph_q <= PH_EVEN;
    else if (cmd_wr_i) ph_q <= PH_EVEN;
    else if (access_i) ph_q <= (ph_q == PH_EVEN) ? PH_ODD : PH_EVEN;
  end

  assign odd_o = (ph_q == PH_ODD);

  assert_cmd_even_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i |=> !odd_o);
  assert_phase_toggle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_i && !cmd_wr_i) |=> (odd_o != $past(odd_o)));
  assert_phase_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!access_i && !cmd_wr_i) |=> $stable(odd_o));
endmodule

// File: rtl/sdp_lane_sel.sv
module sdp_lane_sel #(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] word_i,
  input  logic                odd_i,
  input  logic                big_i,
  output logic [HALF_W-1:0]   half_o
);
  localparam int NB = HALF_W / 8;
  // upper half goes out on LE-odd and BE-even
  logic sel_hi;
  assign sel_hi = odd_i ^ big_i;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign half_o[b*8 +: 8] = sel_hi ? word_i[HALF_W + b*8 +: 8] : word_i[b*8 +: 8];
  end
endmodule

// File: rtl/sdp_wr_pack.sv
module sdp_wr_pack #(
  parameter int HALF_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_even_i,
  input  logic                wr_odd_i,
  input  logic                big_i,
  input  logic [HALF_W-1:0]   data_i,
  output logic                push_o,
  output logic [2*HALF_W-1:0] word_o
);
  logic [HALF_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      push_o <= 1'b0;
      word_o <= '0;
    end else begin
      push_o <= wr_odd_i;
      if (wr_even_i) hold_q <= data_i;
      if (wr_odd_i)  word_o <= big_i ? {hold_q, data_i} : {data_i, hold_q};
    end
  end

  assert_push_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);
  assert_push_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> $past(wr_odd_i));
  assert_even_no_push_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_even_i |=> !push_o);
endmodule

// File: rtl/seq_data_port.sv
module seq_data_port
  import sdp_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int MODE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_wr_i,
  input  logic                mode_wr_i,
  input  logic [MODE_W-1:0]   mode_data_i,
  input  logic                dp_rd_i,
  input  logic                dp_wr_i,
  input  logic [HALF_W-1:0]   host_wdata_i,
  output logic [HALF_W-1:0]   host_rdata_o,
  output logic                big_endian_o,
  output logic                fetch_o,
  input  logic [2*HALF_W-1:0] fetch_data_i,
  output logic                push_o,
  output logic [2*HALF_W-1:0] push_data_o
);
  localparam int WORD_W = 2 * HALF_W;

  logic [MODE_W-1:0] mode_q;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] rd_word;
  logic [HALF_W-1:0] rd_half;
  logic              odd;
  logic              rd_acc, wr_acc;

  // command write wins; read wins over a colliding write
  assign rd_acc = dp_rd_i & ~cmd_wr_i;
  assign wr_acc = dp_wr_i & ~dp_rd_i & ~cmd_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (mode_wr_i) mode_q <= mode_data_i;
  end
  assign big_endian_o = |mode_q;

  sdp_phase u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_wr_i (cmd_wr_i),
    .access_i (rd_acc | wr_acc),
    .odd_o    (odd)
  );

  assign fetch_o = rd_acc & ~odd;
  assign rd_word = odd ? word_q : fetch_data_i;

  sdp_lane_sel #(.HALF_W(HALF_W)) u_rd_sel (
    .word_i (rd_word),
    .odd_i  (odd),
    .big_i  (big_endian_o),
    .half_o (rd_half)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q       <= '0;
      host_rdata_o <= '0;
    end else begin
      if (fetch_o) word_q <= fetch_data_i;
      if (rd_acc)  host_rdata_o <= rd_half;
    end
  end

  sdp_wr_pack #(.HALF_W(HALF_W)) u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_even_i (wr_acc & ~odd),
    .wr_odd_i  (wr_acc & odd),
    .big_i     (big_endian_o),
    .data_i    (host_wdata_i),
    .push_o    (push_o),
    .word_o    (push_data_o)
  );

  assert_fetch_even_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |-> (!odd && !cmd_wr_i && dp_rd_i));
  assert_cmd_blocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i |-> (!fetch_o) ##1 !push_o);
  assert_status_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_wr_i) |-> (big_endian_o == ($past(mode_data_i) != '0)));
  assert_rdata_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_acc) |-> $stable(host_rdata_o));
endmodule

// File: tb/seq_data_port_test.sv
`timescale 1ns/1ps
module seq_data_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0, mode_wr = 1'b0, dp_rd = 1'b0, dp_wr = 1'b0;
  logic [15:0] mode_data = '0, wdata = '0;
  logic [31:0] fdata = '0;
  logic [15:0] rdata;
  logic        big, fetch, push;
  logic [31:0] pdata;

  int errors = 0, checks = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  seq_data_port uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .mode_wr_i(mode_wr),
    .mode_data_i(mode_data), .dp_rd_i(dp_rd), .dp_wr_i(dp_wr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .big_endian_o(big),
    .fetch_o(fetch), .fetch_data_i(fdata), .push_o(push), .push_data_o(pdata)
  );

  // behavioural reference model
  bit          m_odd;
  int unsigned m_mode;
  logic [7:0]  m_bytes[4];
  logic [15:0] m_half, e_rdata;
  bit          e_push;
  logic [31:0] e_pdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_odd = 0; m_mode = 0; m_half = 0; e_rdata = 0; e_push = 0; e_pdata = 0;
      foreach (m_bytes[i]) m_bytes[i] = 8'h00;
    end else begin
      bit be;
      be = (m_mode != 0);
      e_push = 0;
      if (cmd_wr) m_odd = 0;
      else if (dp_rd) begin
        if (!m_odd) for (int i = 0; i < 4; i++) m_bytes[i] = fdata[8*i +: 8];
        if (be == m_odd) e_rdata = {m_bytes[1], m_bytes[0]};
        else             e_rdata = {m_bytes[3], m_bytes[2]};
        m_odd = !m_odd;
      end else if (dp_wr) begin
        if (!m_odd) m_half = wdata;
        else begin
          e_push = 1;
          e_pdata = be ? {m_half, wdata} : {wdata, m_half};
        end
        m_odd = !m_odd;
      end
      if (mode_wr) m_mode = mode_data;
    end
  end

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("host_rdata_o", {16'h0, rdata}, {16'h0, e_rdata});
    check("push_o", {31'h0, push}, {31'h0, e_push});
    if (e_push) check("push_data_o", pdata, e_pdata);
    check("big_endian_o", {31'h0, big}, {31'h0, bit'(m_mode != 0)});
  endtask

  // one cycle: compare registered outputs, drive inputs, check fetch
  task automatic step(bit c, bit r, bit w, logic [15:0] wd, logic [31:0] fd,
                      bit mw = 0, logic [15:0] md = 16'h0);
    @(negedge clk);
    compare_all();
    cmd_wr = c; dp_rd = r; dp_wr = w; wdata = wd; fdata = fd;
    mode_wr = mw; mode_data = md;
    #1;
    check("fetch_o", {31'h0, fetch}, {31'h0, bit'(r && !c && !m_odd)});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 16'h0, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    cur_req = "R1";
    check("reset rdata", {16'h0, rdata}, 32'h0);
    check("reset push", {31'h0, push}, 32'h0);
    check("reset pdata", pdata, 32'h0);
    check("reset big", {31'h0, big}, 32'h0);
    idle(1);

    cur_req = "R4";   // LE read, distinct bytes
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 32'h3322_1100);
    cur_req = "R6";   // odd read with junk on fetch data
    step(0, 1, 0, 0, 32'hDEAD_DEAD);
    cur_req = "R11";
    idle(3);
    check("rdata held R11", {16'h0, rdata}, 32'h0000_3322);

    cur_req = "R7";   // LE write
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 16'hBEEF, 0);
    step(0, 0, 1, 16'hDEAD, 0);
    idle(2);
    cur_req = "R9";   // lone even write, then restart
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 16'h1234, 0);
    step(1, 0, 0, 0, 0);
    idle(2);
    check("no push R9", {31'h0, push}, 32'h0);

    cur_req = "R10";
    step(0, 0, 0, 0, 0, 1, 16'h0100);
    idle(1);
    check("big set R10", {31'h0, big}, 32'h1);

    cur_req = "R5";   // BE read
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 32'h4433_2211);
    step(0, 1, 0, 0, 32'h0BAD_0BAD);
    idle(1);
    check("BE odd read R5", {16'h0, rdata}, 32'h0000_2211);

    cur_req = "R8";   // BE write
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 16'hCAFE, 0);
    step(0, 0, 1, 16'hF00D, 0);
    idle(1);
    check("BE word R8", pdata, 32'hCAFE_F00D);

    cur_req = "R2";   // command colliding with read, and mid-pair restart
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 32'h8877_6655);
    step(1, 1, 0, 0, 32'h1111_1111);
    step(0, 1, 0, 0, 32'hA1A2_A3A4);
    step(1, 0, 1, 16'h7777, 0);
    idle(2);

    cur_req = "R3";   // mixed read/write pair and simultaneous strobes
    step(0, 0, 0, 0, 0, 1, 16'h0000);
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 32'h0102_0304);
    step(0, 0, 1, 16'h5A5A, 0);
    step(0, 1, 1, 16'h9999, 32'hC0C1_C2C3);
    step(0, 1, 1, 16'h8888, 32'hEEEE_EEEE);
    step(0, 0, 1, 16'h4444, 0);
    step(0, 0, 1, 16'h5555, 0);
    idle(2);
    cur_req = "R4";
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 32'hFEDC_BA98);
    idle(1);
    check("LE even read R4", {16'h0, rdata}, 32'h0000_BA98);
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule